// File: doc/BRIEF.md
# Two-Channel Interleaving Request Router

This block sits between one host request port and two memory-controller ports. Every host request carries an address, a read/write flag and 64-bit write data. The router picks one of the two controllers from a single address bit. It then removes that bit from the address it forwards, so both controllers see a dense address space with the same layout. A mode register chooses which address bit does the steering. The choices are cache-line granularity (64-byte lines), page granularity (8 KB pages), bank granularity (above the bank field) and super-bank granularity (above both the bank and the chip-select fields).

Each controller has its own small request queue, and the two controllers drain their queues independently. A stalled channel therefore holds back only the requests aimed at it. Reads may complete out of order across channels. A small tag queue records which channel each read went to, and the router passes read data back to the host strictly in the order the reads were issued. The host data path is 64 bits wide in every mode. Interleaving spreads traffic over two controllers; it does not widen the bus.

Top module: `il_router`

## Requirements
- R1: After reset, `req_ready` is high, no channel request, response or read-accept is asserted, and the mode is cache-line (code 0).
- R2: In mode code 0 (cache line), address bit 6 selects the channel (0 means channel 0). The forwarded address keeps bits 5..0 and shifts bits above 6 down by one.
- R3: In mode code 1 (page), address bit 13 selects the channel and is removed from the forwarded address in the same way.
- R4: In mode code 2 (bank), address bit 16 selects the channel and is removed from the forwarded address.
- R5: In mode code 3 (super-bank), address bit 17 selects the channel and is removed from the forwarded address.
- R6: Each channel queues up to 4 requests. `req_ready` is low while the addressed channel's queue is full. A request to the other channel is still accepted.
- R7: A request accepted at a clock edge appears as a valid request on its channel right after that edge, whatever the other channel is doing.
- R8: Read data returns on `rsp_valid`/`rsp_data` in host issue order. A channel's `ch_rready` is high only when that channel holds the oldest outstanding read, so data waiting on the other channel is not returned early.
- R9: A mode write (`mode_wr` with `mode_in`) takes effect only when both channel queues are empty and no read is outstanding. Otherwise it is dropped.
- R10: The write flag and the 64-bit write data reach the channel unchanged.
- R11: At most 8 reads may be outstanding. With 8 outstanding, a further read is held off (`req_ready` low) while a write is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_in | input | 2 | Mode code: 0 line, 1 page, 2 bank, 3 super-bank |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted this cycle when high with valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Host byte address |
| req_wdata | input | 64 | Host write data |
| rsp_valid | output | 1 | Read data valid (host always accepts) |
| rsp_data | output | 64 | Read data in issue order |
| ch_valid | output | 2 | Per-channel request valid |
| ch_ready | input | 2 | Per-channel request accept |
| ch_we | output | 2 | Per-channel write flag |
| ch_addr | output | 2x31 | Per-channel address with the steering bit removed |
| ch_wdata | output | 2x64 | Per-channel write data |
| ch_rvalid | input | 2 | Per-channel read data valid |
| ch_rready | output | 2 | Per-channel read data accept |
| ch_rdata | input | 2x64 | Per-channel read data |

## Verification
`req_ready` is a combinational function of registered queue state and the current request. A request accepted at an edge is visible on its channel output in the very next cycle. Read data reaches `rsp_data` in the same cycle as the head channel's `ch_rvalid`. The bench drives inputs on the falling edge and samples one time unit later, before the next rising edge. It attributes each transfer to the rising edge that follows. It checks channel presence one sample after each accepted request, and it compares each channel transfer and host response in arrival order against queues filled by its own decode of the host address.

// File: rtl/il_pkg.sv
package il_pkg;

  typedef enum logic [1:0] {
    IL_LINE  = 2'd0,
    IL_PAGE  = 2'd1,
    IL_BANK  = 2'd2,
    IL_SBANK = 2'd3
  } il_mode_e;

  // position of the channel-select bit for a given granularity
  function automatic int unsigned steer_bit(il_mode_e m, int unsigned line_lsb,
                                            int unsigned page_lsb, int unsigned bank_lsb,
                                            int unsigned sbank_lsb);
    case (m)
      IL_LINE: return line_lsb;
      IL_PAGE: return page_lsb;
      IL_BANK: return bank_lsb;
      default: return sbank_lsb;
    endcase
  endfunction

endpackage

// File: rtl/il_fifo.sv
module il_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop); // R8

endmodule

// File: rtl/il_decode.sv
module il_decode
  import il_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LINE_LSB  = 6,
  parameter int PAGE_LSB  = 13,
  parameter int BANK_LSB  = 16,
  parameter int SBANK_LSB = 17
) (
  input  il_mode_e        mode,
  input  logic [AW-1:0]   addr,
  output logic            chan,
  output logic [AW-2:0]   down_addr
);
  localparam int PW = $clog2(AW);

  logic [PW-1:0] pos;
  logic [AW-1:0] keep_lo;
  logic [AW-1:0] squeezed;

  always_comb begin
    pos       = PW'(steer_bit(mode, LINE_LSB, PAGE_LSB, BANK_LSB, SBANK_LSB));
    chan      = addr[pos];
    keep_lo   = (AW'(1) << pos) - AW'(1);
    squeezed  = ((addr >> 1) & ~keep_lo) | (addr & keep_lo);
    down_addr = squeezed[AW-2:0];
  end

endmodule

// File: rtl/il_router.sv
module il_router
  import il_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 64,
  parameter int QDEPTH    = 4,
  parameter int TDEPTH    = 8,
  parameter int LINE_LSB  = 6,
  parameter int PAGE_LSB  = 13,
  parameter int BANK_LSB  = 16,
  parameter int SBANK_LSB = 17
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_wr,
  input  logic [1:0]           mode_in,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_we,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_wdata,
  output logic                 rsp_valid,
  output logic [DW-1:0]        rsp_data,
  output logic [1:0]           ch_valid,
  input  logic [1:0]           ch_ready,
  output logic [1:0]           ch_we,
  output logic [1:0][AW-2:0]   ch_addr,
  output logic [1:0][DW-1:0]   ch_wdata,
  input  logic [1:0]           ch_rvalid,
  output logic [1:0]           ch_rready,
  input  logic [1:0][DW-1:0]   ch_rdata
);
  localparam int QW = 1 + (AW - 1) + DW;

  il_mode_e            mode_q;
  logic                tgt;
  logic [AW-2:0]       dn_addr;
  logic [1:0]          q_empty, q_full;
  logic [1:0][QW-1:0]  q_dout;
  logic                t_empty, t_full, head_ch;
  logic                idle, mode_take, rd_block, fire, rsp_fire;

  // channel decode for the incoming request
  il_decode #(
    .AW(AW), .LINE_LSB(LINE_LSB), .PAGE_LSB(PAGE_LSB),
    .BANK_LSB(BANK_LSB), .SBANK_LSB(SBANK_LSB)
  ) dec_i (
    .mode(mode_q), .addr(req_addr), .chan(tgt), .down_addr(dn_addr)
  );

  // named events
  assign idle      = (&q_empty) && t_empty;
  assign mode_take = mode_wr && idle;
  assign rd_block  = !req_we && t_full;
  assign req_ready = !q_full[tgt] && !rd_block;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)         mode_q <= IL_LINE;
    else if (mode_take) mode_q <= il_mode_e'(mode_in);
  end

  // per-channel request queues
  for (genvar c = 0; c < 2; c++) begin : g_chan
    logic push_c, pop_c;
    assign push_c      = fire && (tgt == 1'(c));
    assign pop_c       = ch_valid[c] && ch_ready[c];
    assign ch_valid[c] = !q_empty[c];
    assign {ch_we[c], ch_addr[c], ch_wdata[c]} = q_dout[c];
    assign ch_rready[c] = !t_empty && (head_ch == 1'(c));

    il_fifo #(.W(QW), .DEPTH(QDEPTH)) q_i (
      .clk(clk), .rst_n(rst_n),
      .push(push_c), .din({req_we, dn_addr, req_wdata}),
      .pop(pop_c), .dout(q_dout[c]),
      .empty(q_empty[c]), .full(q_full[c])
    );
  end

  // read-order tag queue and response merge
  assign rsp_valid = !t_empty && ch_rvalid[head_ch];
  assign rsp_data  = ch_rdata[head_ch];
  assign rsp_fire  = rsp_valid;

  il_fifo #(.W(1), .DEPTH(TDEPTH)) tag_i (
    .clk(clk), .rst_n(rst_n),
    .push(fire && !req_we), .din(tgt),
    .pop(rsp_fire), .dout(head_ch),
    .empty(t_empty), .full(t_full)
  );

  AST_PRESENT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ch_valid[$past(tgt)]); // R7
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(mode_q)); // R9
  AST_ONE_RREADY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_rready)); // R8
  AST_RSP_HEAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_rvalid != 2'b00 && t_empty) |-> !rsp_valid); // R8

endmodule

// File: tb/il_router_tb_top.sv
module il_router_tb_top;
  import il_pkg::*;

  localparam int AW = 32;
  localparam int DW = 64;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic                mode_wr = 0;
  logic [1:0]          mode_in = 0;
  logic                req_valid = 0, req_ready, req_we = 0;
  logic [AW-1:0]       req_addr = 0;
  logic [DW-1:0]       req_wdata = 0;
  logic                rsp_valid;
  logic [DW-1:0]       rsp_data;
  logic [1:0]          ch_valid, ch_we, ch_rready;
  logic [1:0]          ch_ready = 0, ch_rvalid = 0;
  logic [1:0][AW-2:0]  ch_addr;
  logic [1:0][DW-1:0]  ch_wdata;
  logic [1:0][DW-1:0]  ch_rdata = '0;

  il_router dut_i (.*);

  typedef struct packed {
    logic          we;
    logic [AW-2:0] a;
    logic [DW-1:0] d;
    logic [1:0]    m;
  } xfer_t;

  xfer_t          expq[2][$];
  logic [AW-2:0]  pend[2][$];
  logic [DW-1:0]  exp_rsp[$];

  int total = 0, bad = 0, cyc = 0;
  logic          h_valid = 0, h_we = 0, m_wr = 0;
  logic [AW-1:0] h_addr = 0;
  logic [DW-1:0] h_wdata = 0;
  logic [1:0]    m_val = 0, dn_ready = 2'b11, rv_mask = 2'b11;
  logic          rdy_rand = 0, fired = 0, prev_fire = 0, prev_tgt = 0;
  logic [1:0]    b_mode = 0;

  function automatic int b_pos(logic [1:0] m);
    int t[4] = '{6, 13, 16, 17};
    return t[m];
  endfunction

  function automatic logic b_chan(logic [AW-1:0] a, logic [1:0] m);
    return a[b_pos(m)];
  endfunction

  function automatic logic [AW-2:0] b_down(logic [AW-1:0] a, logic [1:0] m);
    logic [AW-2:0] r;
    for (int i = 0; i < AW - 1; i++) r[i] = (i < b_pos(m)) ? a[i] : a[i+1];
    return r;
  endfunction

  function automatic logic [DW-1:0] b_rdata(logic c, logic [AW-2:0] d);
    return ({33'd0, d} * 64'd2654435761) ^ {63'd0, c} ^ 64'hF0F0_0000_0000_1234;
  endfunction

  function automatic string mtag(logic [1:0] m);
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(bit ok, string rq, logic [63:0] act, logic [63:0] exp, string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=%0d exp=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step();
    logic c;
    xfer_t e;
    bit idle_b;
    @(negedge clk);
    req_valid = h_valid; req_we = h_we; req_addr = h_addr; req_wdata = h_wdata;
    mode_wr = m_wr; mode_in = m_val;
    for (int k = 0; k < 2; k++) begin
      ch_ready[k] = rdy_rand ? 1'($urandom % 2) : dn_ready[k];
      if (pend[k].size() > 0 && rv_mask[k] && ($urandom % 3 != 0)) begin
        ch_rvalid[k] = 1'b1;
        ch_rdata[k]  = b_rdata(1'(k), pend[k][0]);
      end else begin
        ch_rvalid[k] = 1'b0;
        ch_rdata[k]  = '0;
      end
    end
    #1;
    if (prev_fire) chk(ch_valid[prev_tgt], "R7", 64'(ch_valid), 64'(prev_tgt), "request not presented next cycle");
    idle_b = expq[0].size() == 0 && expq[1].size() == 0 && exp_rsp.size() == 0;
    for (int k = 0; k < 2; k++) begin
      if (ch_valid[k] && ch_ready[k]) begin
        if (expq[k].size() == 0) begin
          chk(0, "R6", 64'(k), 64'hFF, "unexpected channel request");
        end else begin
          e = expq[k].pop_front();
          chk(ch_addr[k] == e.a, mtag(e.m), 64'(ch_addr[k]), 64'(e.a), "channel address");
          chk(ch_we[k] == e.we && (!e.we || ch_wdata[k] == e.d), "R10",
              ch_wdata[k], e.d, "write flag/data");
          if (!e.we) pend[k].push_back(e.a);
        end
      end
      if (ch_rvalid[k] && ch_rready[k]) void'(pend[k].pop_front());
    end
    if (rsp_valid) begin
      if (exp_rsp.size() == 0) chk(0, "R8", rsp_data, 64'h0, "response with none outstanding");
      else chk(rsp_data == exp_rsp[0], "R8", rsp_data, exp_rsp[0], "response order/data");
      if (exp_rsp.size() > 0) void'(exp_rsp.pop_front());
    end
    fired = 0;
    c = b_chan(req_addr, b_mode);
    if (req_valid && req_ready) begin
      expq[c].push_back('{we: req_we, a: b_down(req_addr, b_mode), d: req_wdata, m: b_mode});
      if (!req_we) exp_rsp.push_back(b_rdata(c, b_down(req_addr, b_mode)));
      fired = 1;
    end
    prev_fire = fired;
    prev_tgt  = c;
    if (m_wr && idle_b) b_mode = m_val;
  endtask

  task automatic send(logic we, logic [AW-1:0] a, logic [DW-1:0] d);
    h_valid = 1; h_we = we; h_addr = a; h_wdata = d;
    for (int i = 0; i < 400; i++) begin
      step();
      if (fired) break;
    end
    h_valid = 0;
  endtask

  task automatic drain();
    h_valid = 0; rdy_rand = 0; dn_ready = 2'b11; rv_mask = 2'b11;
    for (int i = 0; i < 600; i++) begin
      if (expq[0].size() == 0 && expq[1].size() == 0 && exp_rsp.size() == 0 &&
          pend[0].size() == 0 && pend[1].size() == 0) break;
      step();
    end
    step();
  endtask

  task automatic set_mode(logic [1:0] v);
    drain();
    m_wr = 1; m_val = v;
    step();
    m_wr = 0;
  endtask

  initial begin
    void'($urandom(32'h1D0C_5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(req_ready == 1'b1, "R1", 64'(req_ready), 64'd1, "ready after reset");
    chk(ch_valid == 2'b00 && ch_rready == 2'b00, "R1", 64'({ch_valid, ch_rready}), 64'd0, "channel idle");
    chk(rsp_valid == 1'b0, "R1", 64'(rsp_valid), 64'd0, "no response");

    // R2 directed, default mode line (also confirms R1 mode default)
    send(1'b1, 32'h0000_0040, 64'h1111_2222_3333_4444);
    send(1'b1, 32'h0001_0080, 64'hAAAA_BBBB_CCCC_DDDD);
    send(1'b0, 32'h0000_007F, 64'h0);
    drain();

    // random traffic in every mode: R2..R5, R10, R8
    for (int m = 0; m < 4; m++) begin
      set_mode(2'(m));
      rdy_rand = 1;
      for (int n = 0; n < 250; n++) begin
        send(1'($urandom % 2), $urandom, {$urandom, $urandom});
        rdy_rand = 1;
      end
      drain();
    end

    // R6: fill channel 0 queue in line mode
    set_mode(2'd0);
    dn_ready = 2'b00; rdy_rand = 0;
    for (int i = 0; i < 4; i++) send(1'b1, 32'(i * 128), 64'(i));
    h_valid = 1; h_we = 1; h_addr = 32'h200; h_wdata = 64'h5;
    step();
    chk(!req_ready && !fired, "R6", 64'(req_ready), 64'd0, "ready with full queue");
    h_addr = 32'h40;
    step();
    chk(fired, "R6", 64'(fired), 64'd1, "other channel accepted");
    h_valid = 0;
    // R9: mode write while busy is dropped
    m_wr = 1; m_val = 2'd1;
    step();
    m_wr = 0;
    drain();
    send(1'b0, 32'h0000_0040, 64'h0);
    step();
    chk(ch_valid == 2'b10, "R9", 64'(ch_valid), 64'b10, "busy mode write ignored");
    drain();

    // R8: channel 1 answers first but channel 0 read is older
    rv_mask = 2'b10;
    send(1'b0, 32'h0000_0000, 64'h0);
    send(1'b0, 32'h0000_0040, 64'h0);
    rv_mask = 2'b10;
    for (int i = 0; i < 6; i++) begin
      step();
      chk(!rsp_valid && ch_rready != 2'b10, "R8", 64'({rsp_valid, ch_rready}), 64'd0, "younger read held");
    end
    drain();

    // R11: eight reads outstanding
    rv_mask = 2'b00;
    for (int i = 0; i < 8; i++) begin
      send(1'b0, 32'(i * 64), 64'h0);
      rv_mask = 2'b00;
    end
    h_valid = 1; h_we = 0; h_addr = 32'h0;
    step();
    chk(!req_ready && !fired, "R11", 64'(req_ready), 64'd0, "ninth read held");
    h_we = 1; h_wdata = 64'hFEED;
    step();
    chk(fired, "R11", 64'(fired), 64'd1, "write accepted with reads full");
    h_valid = 0;
    drain();

    chk(exp_rsp.size() == 0, "R8", 64'(exp_rsp.size()), 64'd0, "all reads returned");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule